// File: doc/BRIEF.md
# Windowed Bus Address Decoder

This block joins a single bus initiator to a fixed group of subordinate ports on a Wishbone-style bus. Each subordinate owns one address window. A window's base and size are parameters, given as word addresses. Every window is aligned to its size, and the size is a power of two. The decoder is purely combinational. It compares the initiator's word address with every window and raises the cycle line of the one subordinate that matches. It passes the request on and routes that subordinate's response back to the initiator.

Request data, strobe and write enable leave the block on shared wires that every subordinate sees. Each subordinate also gets its own copy of the address, reduced to the offset inside its window, and its own byte-select vector. The byte-select vector is shaped by how that subordinate is attached. A subordinate can be attached in one of three ways:
- at the decoder's 16-bit select granularity;
- densely, at finer 8-bit granularity, where each decoder select bit is widened to two byte selects;
- sparsely, as a 16-bit-wide device that holds only the low data lane.

Optional responses (error, retry, stall) and the burst attributes (lock, cycle type, burst extension) are enabled separately for each subordinate.

Top module: `wb_window_decoder`

## Requirements
- R1: Subordinate i has its cycle line high exactly when the initiator cycle is high and `base_i <= m_adr < base_i + size_i`. The default windows, in words, are 0x100..0x1FF, 0x400..0x5FF and 0x800..0x8FF.
- R2: Each subordinate's address output equals `m_adr & (size_i - 1)`. For the subordinate that is hit, this is the offset within its window.
- R3: At most one subordinate cycle line is high at any time.
- R4: Strobe, write enable and write data are passed unchanged to the shared subordinate outputs, whether or not any window is hit.
- R5: Acknowledge, read data, error, retry and stall at the initiator come only from the subordinate that is hit. The values driven by the other subordinates have no effect.
- R6: If the subordinate that is hit does not implement error, retry or stall, the initiator sees 0 for that signal. By default, error is implemented on subordinates 0 and 1, and retry and stall only on subordinate 1.
- R7: Lock, cycle type (3 bits) and burst extension (2 bits) are forwarded unchanged to subordinates that implement them (by default only subordinate 1). Every other subordinate receives zeros. For example, incrementing burst 3'b010 and 4-beat wrap 2'b01 arrive as they were sent.
- R8: While the initiator cycle is low, no subordinate cycle line is high, and acknowledge, error, retry, stall and read data at the initiator are all 0.
- R9: An address outside every window selects no subordinate. Acknowledge, error, retry, stall and read data at the initiator are then 0.
- R10: On the dense fine-granularity subordinate (1), decoder select bit k drives byte selects 2k and 2k+1.
- R11: On the same-granularity subordinate (0), byte selects [1:0] equal the decoder select bits, and byte selects [3:2] are 0.
- R12: On the sparse subordinate (2), only byte select 0 is driven, from decoder select bit 0. Read data from that subordinate keeps bits [15:0], and bits [31:16] read as 0 whatever the subordinate drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_cyc | input | 1 | Initiator cycle |
| m_stb | input | 1 | Initiator strobe |
| m_we | input | 1 | Initiator write enable |
| m_adr | input | 16 | Initiator word address |
| m_dat_w | input | 32 | Initiator write data |
| m_sel | input | 2 | Initiator select, one bit per 16-bit unit |
| m_lock | input | 1 | Initiator lock |
| m_cti | input | 3 | Initiator cycle type |
| m_bte | input | 2 | Initiator burst extension |
| m_dat_r | output | 32 | Read data to initiator |
| m_ack | output | 1 | Acknowledge to initiator |
| m_err | output | 1 | Error to initiator |
| m_rty | output | 1 | Retry to initiator |
| m_stall | output | 1 | Stall to initiator |
| s_cyc | output | 3 | Per-subordinate cycle |
| s_stb | output | 1 | Shared strobe |
| s_we | output | 1 | Shared write enable |
| s_dat_w | output | 32 | Shared write data |
| s_adr | output | 48 | Per-subordinate window offset, 16 bits each |
| s_sel | output | 12 | Per-subordinate byte selects, 4 bits each |
| s_lock | output | 3 | Per-subordinate lock |
| s_cti | output | 9 | Per-subordinate cycle type, 3 bits each |
| s_bte | output | 6 | Per-subordinate burst extension, 2 bits each |
| s_dat_r | input | 96 | Per-subordinate read data, 32 bits each |
| s_ack | input | 3 | Per-subordinate acknowledge |
| s_err | input | 3 | Per-subordinate error |
| s_rty | input | 3 | Per-subordinate retry |
| s_stall | input | 3 | Per-subordinate stall |

## Verification
The block has no registers, so every result is due in the same cycle as the stimulus that causes it, with zero cycles of latency. The bench changes all inputs together and then waits a fixed 2 ns settling gap before it samples, which keeps every check well clear of the clock edge.

The sweep covers addresses across the whole map and the first and last word on both sides of each window. For each address it varies:
- the initiator cycle line;
- the select patterns;
- the burst attributes;
- the subordinate response patterns.

Expected values are computed arithmetically from the window table.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;

    // How a subordinate's data lanes relate to the decoder's
    typedef enum logic [1:0] {
        MAP_SAME   = 2'd0,
        MAP_FINE   = 2'd1,
        MAP_SPARSE = 2'd2
    } map_kind_e;

    localparam int CTI_W = 3;
    localparam int BTE_W = 2;

    typedef struct packed {
        logic             lock;
        logic [CTI_W-1:0] cti;
        logic [BTE_W-1:0] bte;
    } burst_attr_t;

    typedef struct packed {
        logic ack;
        logic err;
        logic rty;
        logic stall;
    } resp_flags_t;

    function automatic logic in_window(input logic [63:0] adr,
                                       input logic [63:0] base,
                                       input logic [63:0] size);
        return (adr >= base) && (adr < base + size);
    endfunction

endpackage

// File: rtl/wbdec_match.sv
module wbdec_match
    import wbdec_pkg::*;
#(
    parameter int              N        = 3,
    parameter int              AW       = 16,
    parameter logic [N*AW-1:0] WIN_BASE = '0,
    parameter logic [N*AW-1:0] WIN_SIZE = '0
) (
    input  logic [AW-1:0] adr,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_win
        assign hit[i] = in_window(64'(adr),
                                  64'(WIN_BASE[i*AW +: AW]),
                                  64'(WIN_SIZE[i*AW +: AW]));
    end

    always_comb begin
        if (!$isunknown(adr)) begin
            p_single_hit_r3: assert ($onehot0(hit))
                else $error("overlapping windows hit together");
        end
    end
endmodule

// File: rtl/wbdec_req_fanout.sv
module wbdec_req_fanout
    import wbdec_pkg::*;
#(
    parameter int              N        = 3,
    parameter int              AW       = 16,
    parameter int              SW       = 2,
    parameter int              BL       = 4,
    parameter logic [N*AW-1:0] WIN_SIZE = '0,
    parameter logic [2*N-1:0]  SUB_KIND = '0,
    parameter logic [N-1:0]    HAS_ATTR = '0
) (
    input  logic [AW-1:0]   adr,
    input  logic [SW-1:0]   sel,
    input  burst_attr_t     attr,
    output logic [N*AW-1:0] sub_adr,
    output logic [N*BL-1:0] sub_sel,
    output burst_attr_t     sub_attr [N]
);
    localparam int RATIO = BL / SW;

    for (genvar i = 0; i < N; i++) begin : g_sub
        localparam logic [AW-1:0] MASK = WIN_SIZE[i*AW +: AW] - AW'(1);
        assign sub_adr[i*AW +: AW] = adr & MASK;

        for (genvar k = 0; k < BL; k++) begin : g_lane
            if (SUB_KIND[2*i +: 2] == MAP_FINE) begin : g_fine
                assign sub_sel[i*BL + k] = sel[k / RATIO];
            end else if (SUB_KIND[2*i +: 2] == MAP_SPARSE) begin : g_sparse
                if (k == 0) begin : g_low
                    assign sub_sel[i*BL + k] = sel[0];
                end else begin : g_hi
                    assign sub_sel[i*BL + k] = 1'b0;
                end
            end else begin : g_same
                if (k < SW) begin : g_used
                    assign sub_sel[i*BL + k] = sel[k];
                end else begin : g_unused
                    assign sub_sel[i*BL + k] = 1'b0;
                end
            end
        end

        if (HAS_ATTR[i]) begin : g_attr
            assign sub_attr[i] = attr;
        end else begin : g_noattr
            assign sub_attr[i] = '0;
        end

        if (SUB_KIND[2*i +: 2] == MAP_SPARSE) begin : g_chk
            always_comb begin
                if (!$isunknown(sel)) begin
                    p_sparse_lane_r12: assert (sub_sel[i*BL + 1 +: BL-1] == '0)
                        else $error("sparse port got upper selects");
                end
            end
        end
    end
endmodule

// File: rtl/wbdec_resp_mux.sv
module wbdec_resp_mux
    import wbdec_pkg::*;
#(
    parameter int             N         = 3,
    parameter int             DW        = 32,
    parameter int             GRAN      = 16,
    parameter logic [2*N-1:0] SUB_KIND  = '0,
    parameter logic [N-1:0]   HAS_ERR   = '0,
    parameter logic [N-1:0]   HAS_RTY   = '0,
    parameter logic [N-1:0]   HAS_STALL = '0
) (
    input  logic [N-1:0]    route,
    input  logic [N*DW-1:0] sub_dat,
    input  resp_flags_t     sub_flags [N],
    output logic [DW-1:0]   dat,
    output resp_flags_t     flags
);
    localparam logic [DW-1:0] LANE0 = {{(DW-GRAN){1'b0}}, {GRAN{1'b1}}};

    always_comb begin
        dat   = '0;
        flags = '0;
        for (int i = 0; i < N; i++) begin
            if (route[i]) begin
                dat         |= (SUB_KIND[2*i +: 2] == MAP_SPARSE)
                               ? (sub_dat[i*DW +: DW] & LANE0)
                               : sub_dat[i*DW +: DW];
                flags.ack   |= sub_flags[i].ack;
                flags.err   |= sub_flags[i].err   & HAS_ERR[i];
                flags.rty   |= sub_flags[i].rty   & HAS_RTY[i];
                flags.stall |= sub_flags[i].stall & HAS_STALL[i];
            end
        end
    end

    always_comb begin
        if (!$isunknown(route) && route == '0) begin
            p_quiet_unrouted_r9: assert (flags == '0 && dat == '0)
                else $error("response leaked with no route");
        end
    end
endmodule

// File: rtl/wb_window_decoder.sv
module wb_window_decoder
    import wbdec_pkg::*;
#(
    parameter int              N         = 3,
    parameter int              AW        = 16,
    parameter int              DW        = 32,
    parameter int              GRAN      = 16,
    parameter logic [N*AW-1:0] WIN_BASE  = {16'h0800, 16'h0400, 16'h0100},
    parameter logic [N*AW-1:0] WIN_SIZE  = {16'h0100, 16'h0200, 16'h0100},
    parameter logic [2*N-1:0]  SUB_KIND  = {2'd2, 2'd1, 2'd0},
    parameter logic [N-1:0]    HAS_ERR   = 3'b011,
    parameter logic [N-1:0]    HAS_RTY   = 3'b010,
    parameter logic [N-1:0]    HAS_STALL = 3'b010,
    parameter logic [N-1:0]    HAS_ATTR  = 3'b010,
    localparam int             SW        = DW / GRAN,
    localparam int             BL        = DW / 8
) (
    input  logic              m_cyc,
    input  logic              m_stb,
    input  logic              m_we,
    input  logic [AW-1:0]     m_adr,
    input  logic [DW-1:0]     m_dat_w,
    input  logic [SW-1:0]     m_sel,
    input  logic              m_lock,
    input  logic [2:0]        m_cti,
    input  logic [1:0]        m_bte,
    output logic [DW-1:0]     m_dat_r,
    output logic              m_ack,
    output logic              m_err,
    output logic              m_rty,
    output logic              m_stall,
    output logic [N-1:0]      s_cyc,
    output logic              s_stb,
    output logic              s_we,
    output logic [DW-1:0]     s_dat_w,
    output logic [N*AW-1:0]   s_adr,
    output logic [N*BL-1:0]   s_sel,
    output logic [N-1:0]      s_lock,
    output logic [N*3-1:0]    s_cti,
    output logic [N*2-1:0]    s_bte,
    input  logic [N*DW-1:0]   s_dat_r,
    input  logic [N-1:0]      s_ack,
    input  logic [N-1:0]      s_err,
    input  logic [N-1:0]      s_rty,
    input  logic [N-1:0]      s_stall
);
    logic [N-1:0] hit;
    logic [N-1:0] route;
    burst_attr_t  req_attr;
    burst_attr_t  sub_attr [N];
    resp_flags_t  sub_flags [N];
    resp_flags_t  up_flags;

    wbdec_match #(.N(N), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE))
        u_match (.adr(m_adr), .hit(hit));

    assign route    = hit & {N{m_cyc}};
    assign s_cyc    = route;
    assign s_stb    = m_stb;
    assign s_we     = m_we;
    assign s_dat_w  = m_dat_w;
    assign req_attr = '{lock: m_lock, cti: m_cti, bte: m_bte};

    wbdec_req_fanout #(.N(N), .AW(AW), .SW(SW), .BL(BL), .WIN_SIZE(WIN_SIZE),
                       .SUB_KIND(SUB_KIND), .HAS_ATTR(HAS_ATTR))
        u_fanout (.adr(m_adr), .sel(m_sel), .attr(req_attr),
                  .sub_adr(s_adr), .sub_sel(s_sel), .sub_attr(sub_attr));

    for (genvar i = 0; i < N; i++) begin : g_port
        assign s_lock[i]       = sub_attr[i].lock;
        assign s_cti[i*3 +: 3] = sub_attr[i].cti;
        assign s_bte[i*2 +: 2] = sub_attr[i].bte;
        assign sub_flags[i]    = '{ack: s_ack[i], err: s_err[i],
                                   rty: s_rty[i], stall: s_stall[i]};
    end

    wbdec_resp_mux #(.N(N), .DW(DW), .GRAN(GRAN), .SUB_KIND(SUB_KIND),
                     .HAS_ERR(HAS_ERR), .HAS_RTY(HAS_RTY), .HAS_STALL(HAS_STALL))
        u_resp (.route(route), .sub_dat(s_dat_r), .sub_flags(sub_flags),
                .dat(m_dat_r), .flags(up_flags));

    assign m_ack   = up_flags.ack;
    assign m_err   = up_flags.err;
    assign m_rty   = up_flags.rty;
    assign m_stall = up_flags.stall;

    always_comb begin
        if (!$isunknown({m_cyc, m_adr})) begin
            p_idle_no_cycle_r8: assert (m_cyc || s_cyc == '0)
                else $error("subordinate cycle without initiator cycle");
            p_one_cycle_r3: assert ($onehot0(s_cyc))
                else $error("more than one subordinate cycle");
        end
    end
endmodule

// File: tb/test_wb_window_decoder.sv
module test_wb_window_decoder;
    localparam int N = 3, AW = 16, DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              m_cyc, m_stb, m_we, m_lock;
    logic [AW-1:0]     m_adr;
    logic [DW-1:0]     m_dat_w, m_dat_r;
    logic [1:0]        m_sel, m_bte;
    logic [2:0]        m_cti;
    logic              m_ack, m_err, m_rty, m_stall;
    logic [N-1:0]      s_cyc, s_lock, s_ack, s_err, s_rty, s_stall;
    logic              s_stb, s_we;
    logic [DW-1:0]     s_dat_w;
    logic [N*AW-1:0]   s_adr;
    logic [N*4-1:0]    s_sel;
    logic [N*3-1:0]    s_cti;
    logic [N*2-1:0]    s_bte;
    logic [N*DW-1:0]   s_dat_r;

    wb_window_decoder i_wb_window_decoder (.*);

    int tests = 0, fails = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s adr=%h cyc=%0d actual=%h expected=%h", tag, m_adr, m_cyc, act, exp);
        end
    endtask

    function automatic int sub_base(input int i);
        return (i == 0) ? 'h100 : (i == 1) ? 'h400 : 'h800;
    endfunction
    function automatic int sub_size(input int i);
        return (i == 1) ? 'h200 : 'h100;
    endfunction

    task automatic apply_and_check(input int a, input logic cyc, input logic [1:0] sel, input int p);
        int        hit_idx;
        logic [2:0] exp_cyc;
        logic [31:0] dat [3];
        logic [3:0]  esel [3];
        m_adr   = AW'(a);
        m_cyc   = cyc;
        m_stb   = a[0];
        m_we    = a[1];
        m_sel   = sel;
        m_dat_w = 32'hC0DE_0000 | 32'(a);
        m_lock  = p[0];
        m_cti   = p[1] ? 3'b010 : 3'b111;
        m_bte   = p[1] ? 2'b01 : 2'b10;
        s_ack   = p[0] ? 3'b101 : 3'b010;
        s_err   = p[1] ? 3'b111 : 3'b000;
        s_rty   = p[1] ? 3'b000 : 3'b111;
        s_stall = p[0] ? 3'b010 : 3'b101;
        dat[0] = 32'h1111_2222 ^ 32'(a);
        dat[1] = 32'h3333_4444 ^ 32'(a);
        dat[2] = 32'hDEAD_5A5A ^ 32'(a);
        s_dat_r = {dat[2], dat[1], dat[0]};
        #2;
        hit_idx = -1;
        for (int i = 0; i < N; i++)
            if (a >= sub_base(i) && a < sub_base(i) + sub_size(i)) hit_idx = i;
        exp_cyc = (cyc && hit_idx >= 0) ? 3'(1 << hit_idx) : 3'b000;
        chk("R1/R3/R8 s_cyc", 64'(s_cyc), 64'(exp_cyc));
        for (int i = 0; i < N; i++)
            chk("R2 s_adr", 64'(s_adr[i*AW +: AW]), 64'(a % sub_size(i)));
        chk("R4 s_stb/s_we", 64'({s_stb, s_we}), 64'({a[0], a[1]}));
        chk("R4 s_dat_w", 64'(s_dat_w), 64'(32'hC0DE_0000 | 32'(a)));
        esel[0] = {2'b00, sel};
        esel[1] = {sel[1], sel[1], sel[0], sel[0]};
        esel[2] = {3'b000, sel[0]};
        chk("R11 sel sub0", 64'(s_sel[3:0]), 64'(esel[0]));
        chk("R10 sel sub1", 64'(s_sel[7:4]), 64'(esel[1]));
        chk("R12 sel sub2", 64'(s_sel[11:8]), 64'(esel[2]));
        chk("R7 attr sub1", 64'({s_lock[1], s_cti[5:3], s_bte[3:2]}),
            64'({p[0], p[1] ? 3'b010 : 3'b111, p[1] ? 2'b01 : 2'b10}));
        chk("R7 attr sub0/2 zero", 64'({s_lock[0], s_lock[2], s_cti[2:0], s_cti[8:6],
                                        s_bte[1:0], s_bte[5:4]}), 64'(0));
        if (!cyc) begin
            chk("R8 idle response", 64'({m_ack, m_err, m_rty, m_stall, m_dat_r}), 64'(0));
        end else if (hit_idx < 0) begin
            chk("R9 unmapped response", 64'({m_ack, m_err, m_rty, m_stall, m_dat_r}), 64'(0));
        end else begin
            chk("R5 ack", 64'(m_ack), 64'(s_ack[hit_idx]));
            chk("R6 err", 64'(m_err), 64'(s_err[hit_idx] & (hit_idx != 2)));
            chk("R6 rty/stall", 64'({m_rty, m_stall}),
                64'({s_rty[hit_idx] & (hit_idx == 1), s_stall[hit_idx] & (hit_idx == 1)}));
            if (hit_idx == 2) chk("R12 sparse dat_r", 64'(m_dat_r), 64'(dat[2] & 32'h0000_FFFF));
            else              chk("R5 dat_r", 64'(m_dat_r), 64'(dat[hit_idx]));
        end
        #6;
    endtask

    initial begin
        m_cyc = 0; m_stb = 0; m_we = 0; m_adr = 0; m_dat_w = 0; m_sel = 0;
        m_lock = 0; m_cti = 0; m_bte = 0;
        s_dat_r = '0; s_ack = '1; s_err = '1; s_rty = '1; s_stall = '1;
        #2;
        chk("R8 initial idle", 64'({s_cyc, m_ack, m_err, m_rty, m_stall, m_dat_r}), 64'(0));
        #6;
        for (int a = 0; a < 'hA00; a += 'h20)
            for (int c = 0; c < 2; c++)
                for (int s = 1; s < 4; s++)
                    for (int p = 0; p < 4; p++)
                        apply_and_check(a + (a >> 5) % 7, c[0], 2'(s), p);
        for (int i = 0; i < N; i++) begin
            int edges [4];
            edges[0] = sub_base(i) - 1;
            edges[1] = sub_base(i);
            edges[2] = sub_base(i) + sub_size(i) - 1;
            edges[3] = sub_base(i) + sub_size(i);
            for (int e = 0; e < 4; e++)
                for (int s = 1; s < 4; s++)
                    for (int p = 0; p < 4; p++)
                        apply_and_check(edges[e], 1'b1, 2'(s), p);
        end
        done = 1'b1;
    end

    initial begin
        int cyc_count = 0;
        while (!done && cyc_count < 100000) begin
            @(posedge clk);
            cyc_count++;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule